// File: doc/BRIEF.md
# Interrupt Pending/Active State Tracker

This block follows a small bank of peripheral interrupt lines and keeps, for each line, one of four states: idle, pending, active, or active with a further request waiting. Each line is set up as level-sensitive or as pulse. The raw inputs pass through a synchronizer before they are used. A line becomes pending when hardware raises it or when software asks for it, either through a per-line set mask or by writing a line number to a trigger port. Software can also withdraw a pending request through a clear mask.

A simple core model sees one request at a time: the lowest-numbered line that is pending, enabled and not already in its handler. The core moves a line into its handler with an entry strobe carrying the line number, and takes it out again with a return strobe. Level and pulse lines differ when the handler returns and when software clears them. The enable bits only decide which lines are offered to the core. They never stop a line from becoming pending.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every line is idle (`pend_o` and `act_o` all zero) and `req_valid` is 0.
- R2: A level line (`line_is_pulse` bit 0) that is not active becomes pending when its input is high. The state shows the change three clock edges after the input rises: two synchronizer flops, then the state register.
- R3: A pulse line (`line_is_pulse` bit 1) becomes pending on a rising edge of its synchronized input, three edges after the input rises. It stays pending after the input falls again.
- R4: A line becomes pending when its `sw_set` bit is high, or when `trig_valid` is high with `trig_id` equal to its number. This happens whatever its enable bit is. If set and clear hit the same line in the same cycle, the set wins.
- R5: An entry strobe (`enter_valid`, `enter_id`) for a line in the pending state moves that line to active and clears its pending flag. An entry strobe for a line that is not pending has no effect.
- R6: When a level line returns from its handler (`exit_valid`, `exit_id`), it becomes pending if its synchronized input is high, and idle otherwise.
- R7: A rising edge or a software set on an active pulse line moves it to active-and-pending. When the handler returns, that line becomes pending. A pulse line with no new request while active becomes idle when the handler returns.
- R8: A software clear on a level line has no effect while its synchronized input is high. Otherwise it removes the pending flag.
- R9: A software clear on a pulse line moves pending to idle, and active-and-pending to active.
- R10: `req_line_o[i]` is high exactly when line i is pending, enabled and not active. `req_valid` is high when any bit of `req_line_o` is high, and `req_id` then gives the lowest such line number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt inputs |
| line_is_pulse | input | NUM_LINES | 1 = pulse line, 0 = level line |
| line_en | input | NUM_LINES | Enable mask for offering lines to the core |
| sw_set | input | NUM_LINES | Software set-pending strobes |
| sw_clr | input | NUM_LINES | Software clear-pending strobes |
| trig_valid | input | 1 | Trigger-by-number strobe |
| trig_id | input | ID_W | Line number to trigger |
| enter_valid | input | 1 | Core handler-entry strobe |
| enter_id | input | ID_W | Line being entered |
| exit_valid | input | 1 | Core handler-return strobe |
| exit_id | input | ID_W | Line returning |
| pend_o | output | NUM_LINES | Per-line pending flag |
| act_o | output | NUM_LINES | Per-line active flag |
| req_line_o | output | NUM_LINES | Per-line request flag |
| req_valid | output | 1 | A request is offered |
| req_id | output | ID_W | Lowest-numbered requesting line |

## Verification
The state that is hardest to reach from the ports is active-and-pending on a pulse line, followed by a software clear or a handler return. To get there, the stimulus first enters the handler and then sends a second request while the line is still active. That second request is either a software set or a short input pulse timed through the synchronizer. The bench then checks the clear and return paths against each other. A table of software-driven steps covers the pulse-line cases in sequence, and directed tests add input-driven level and pulse behaviour.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2,
    ST_BOTH = 2'd3
  } line_st_e;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int NUM_LINES = 8,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] raw_i,
  output logic [NUM_LINES-1:0] lvl_o,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] stg_q [STAGES];
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;

  // R3
  rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((prev_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
  import irq_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic is_pulse,
  input  logic lvl,
  input  logic rise,
  input  logic set,
  input  logic clr,
  input  logic enter,
  input  logic leave,
  output logic pend_o,
  output logic act_o
);
  line_st_e st_q, st_d;
  logic     hw_req;
  logic     st_en;

  assign hw_req = is_pulse ? rise : lvl;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (set || hw_req) st_d = ST_PEND;
      ST_PEND: begin
        if (enter)
          st_d = (set || (is_pulse && rise)) ? ST_BOTH : ST_ACT;
        else if (clr && !set)
          st_d = (!is_pulse && lvl) ? ST_PEND : ST_IDLE;
      end
      ST_ACT: begin
        if (leave)
          st_d = (set || hw_req) ? ST_PEND : ST_IDLE;
        else if (set || (is_pulse && rise))
          st_d = ST_BOTH;
      end
      ST_BOTH: begin
        if (leave)
          st_d = ST_PEND;
        else if (clr && !set && (is_pulse || !lvl))
          st_d = ST_ACT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign pend_o = (st_q == ST_PEND) || (st_q == ST_BOTH);
  assign act_o  = (st_q == ST_ACT)  || (st_q == ST_BOTH);

  // R5
  enter_moves_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND && enter) |=> act_o);
  // R9
  pulse_clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pulse && st_q == ST_PEND && clr && !set && !enter) |=> (st_q == ST_IDLE));
  // R7
  both_leave_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BOTH && leave) |=> (st_q == ST_PEND));
  // R6
  level_leave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_pulse && st_q == ST_ACT && leave && !lvl && !set) |=> (st_q == ST_IDLE));
  // R8
  level_clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_pulse && st_q == ST_PEND && clr && lvl && !enter) |=> pend_o);
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int NUM_LINES = 8,
  localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] cand_i,
  output logic                 valid_o,
  output logic [ID_W-1:0]      id_o
);
  always_comb begin
    id_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (cand_i[i]) id_o = ID_W'(i);
  end
  assign valid_o = |cand_i;

  // R10
  pick_is_cand_chk: assert final (!valid_o || cand_i[id_o]);
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int NUM_LINES = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] line_is_pulse,
  input  logic [NUM_LINES-1:0] line_en,
  input  logic [NUM_LINES-1:0] sw_set,
  input  logic [NUM_LINES-1:0] sw_clr,
  input  logic                 trig_valid,
  input  logic [ID_W-1:0]      trig_id,
  input  logic                 enter_valid,
  input  logic [ID_W-1:0]      enter_id,
  input  logic                 exit_valid,
  input  logic [ID_W-1:0]      exit_id,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] act_o,
  output logic [NUM_LINES-1:0] req_line_o,
  output logic                 req_valid,
  output logic [ID_W-1:0]      req_id
);
  logic [NUM_LINES-1:0] lvl_s, rise_s;

  irq_in_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_in), .lvl_o(lvl_s), .rise_o(rise_s)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic set_g, enter_g, leave_g;
    assign set_g   = sw_set[g] || (trig_valid && trig_id == ID_W'(g));
    assign enter_g = enter_valid && enter_id == ID_W'(g);
    assign leave_g = exit_valid && exit_id == ID_W'(g) && act_o[g];

    irq_line_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .is_pulse(line_is_pulse[g]),
      .lvl(lvl_s[g]), .rise(rise_s[g]), .set(set_g), .clr(sw_clr[g]),
      .enter(enter_g), .leave(leave_g),
      .pend_o(pend_o[g]), .act_o(act_o[g])
    );
  end

  assign req_line_o = pend_o & line_en & ~act_o;

  irq_low_pick #(.NUM_LINES(NUM_LINES)) u_pick (
    .cand_i(req_line_o), .valid_o(req_valid), .id_o(req_id)
  );

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((pend_o & $past(sw_set)) == $past(sw_set)));
endmodule

// File: tb/irq_state_tracker_test.sv
module irq_state_tracker_test;
  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam int NSTEP = 13;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0, line_is_pulse = 8'hF0, line_en = 8'hFD;
  logic [N-1:0] sw_set = '0, sw_clr = '0;
  logic trig_valid = 0, enter_valid = 0, exit_valid = 0;
  logic [2:0] trig_id = '0, enter_id = '0, exit_id = '0;
  logic [N-1:0] pend_o, act_o, req_line_o;
  logic req_valid;
  logic [2:0] req_id;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_state_tracker uut (.*);

  // fields: set, clr, env, enid, exv, exid, exp pend, exp act, exp rv, exp rid
  localparam logic [43:0] VEC [NSTEP] = '{
    {8'h02, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 8'h02, 8'h00, 1'b0, 3'd0},
    {8'h10, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 8'h12, 8'h00, 1'b1, 3'd4},
    {8'h00, 8'h00, 1'b1, 3'd4, 1'b0, 3'd0, 8'h02, 8'h10, 1'b0, 3'd0},
    {8'h10, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 8'h12, 8'h10, 1'b0, 3'd0},
    {8'h00, 8'h10, 1'b0, 3'd0, 1'b0, 3'd0, 8'h02, 8'h10, 1'b0, 3'd0},
    {8'h10, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 8'h12, 8'h10, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 3'd4, 8'h12, 8'h00, 1'b1, 3'd4},
    {8'h01, 8'h01, 1'b0, 3'd0, 1'b0, 3'd0, 8'h13, 8'h00, 1'b1, 3'd0},
    {8'h00, 8'h10, 1'b0, 3'd0, 1'b0, 3'd0, 8'h03, 8'h00, 1'b1, 3'd0},
    {8'h00, 8'h00, 1'b1, 3'd0, 1'b0, 3'd0, 8'h02, 8'h01, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b1, 3'd5, 1'b0, 3'd0, 8'h02, 8'h01, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b0, 3'd0, 1'b1, 3'd0, 8'h02, 8'h00, 1'b0, 3'd0},
    {8'h00, 8'h02, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_clear;
    @(negedge clk);
    sw_set = '0; sw_clr = '0; trig_valid = 0; enter_valid = 0; exit_valid = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1 pend", pend_o, 0);
    chk("R1 act", act_o, 0);
    chk("R1 req_valid", req_valid, 0);
    rst_n = 1;
    idle(1);

    // table: lines 0-3 level, 4-7 pulse, line 1 disabled, inputs low
    for (int i = 0; i < NSTEP; i++) begin
      logic [43:0] v;
      v = VEC[i];
      sw_set = v[43:36]; sw_clr = v[35:28];
      enter_valid = v[27]; enter_id = v[26:24];
      exit_valid = v[23]; exit_id = v[22:20];
      pulse_clear();
      // R4 R5 R7 R9 sequence
      chk($sformatf("R9/R7/R5/R4 step%0d pend", i), pend_o, v[19:12]);
      chk($sformatf("R5/R7 step%0d act", i), act_o, v[11:4]);
      chk($sformatf("R10 step%0d req_valid", i), req_valid, v[3]);
      if (v[3]) chk($sformatf("R10 step%0d req_id", i), req_id, v[2:0]);
    end

    // R2: level line 2 input high
    irq_in[2] = 1;
    idle(2);
    chk("R2 not yet pending", pend_o[2], 0);
    idle(1);
    chk("R2 level pending", pend_o[2], 1);
    chk("R10 req_line", req_line_o, 8'h04);
    // R8: clear while high has no effect
    sw_clr = 8'h04; pulse_clear();
    chk("R8 clear ignored while high", pend_o[2], 1);
    enter_valid = 1; enter_id = 2; pulse_clear();
    chk("R5 level act", {pend_o[2], act_o[2]}, 2'b01);
    exit_valid = 1; exit_id = 2; pulse_clear();
    chk("R6 level re-pend on exit", {pend_o[2], act_o[2]}, 2'b10);
    irq_in[2] = 0; idle(3);
    sw_clr = 8'h04; pulse_clear();
    chk("R8 clear when low", pend_o[2], 0);
    enter_valid = 1; enter_id = 2; pulse_clear();
    chk("R5 enter on idle line ignored", act_o[2], 0);

    // R3: pulse line 6
    irq_in[6] = 1; idle(1); irq_in[6] = 0;
    idle(2);
    chk("R3 pulse pending", pend_o[6], 1);
    idle(3);
    chk("R3 still pending after fall", pend_o[6], 1);
    enter_valid = 1; enter_id = 6; pulse_clear();
    irq_in[6] = 1; idle(1); irq_in[6] = 0; idle(3);
    chk("R7 pulse while active", {pend_o[6], act_o[6]}, 2'b11);
    exit_valid = 1; exit_id = 6; pulse_clear();
    chk("R7 exit to pending", {pend_o[6], act_o[6]}, 2'b10);
    enter_valid = 1; enter_id = 6; pulse_clear();
    exit_valid = 1; exit_id = 6; pulse_clear();
    chk("R7 exit to idle", {pend_o[6], act_o[6]}, 2'b00);

    // R4 trigger by number, R10 lowest pick
    trig_valid = 1; trig_id = 7; pulse_clear();
    chk("R4 trigger by number", pend_o, 8'h80);
    chk("R10 pick 7", req_id, 3'd7);
    sw_set = 8'h40; pulse_clear();
    chk("R10 pick lowest", req_id, 3'd6);
    sw_set = 8'h02; pulse_clear();
    chk("R10 disabled skipped", req_id, 3'd6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule